// File: doc/BRIEF.md
# Card Status Word Register

This block holds the 32-bit status word that a memory card returns in its short responses. Individual error and status flags are raised by single-cycle event pulses from the card's command and data logic. Each flag is cleared in one of two ways. Some clear once a response that showed them has been sent. Others clear when the next command is received. The card-state fields are not stored as flags: the locked indication, the ECC-disabled indication, the ready-for-data flag and the 4-bit current-state code are copied straight from live card inputs.

The word handed to the response serializer is a snapshot. It is taken on the clock edge at which a command (any valid command or a status request) is accepted. That snapshot is what one response carries. It keeps the response stable while it is being shifted out. It also means that an error raised after the command was accepted, during execution, shows up only in a later response, normally the one to a status request. Command decoding and serialization sit outside this block. The block sees only the strobes and the event pulses.

Top module: `cs_status_reg`

## Requirements
- R1: After reset the response word is all zeros and every latched flag is clear.
- R2: A one-cycle pulse on `ev_range_i`, `ev_addr_i`, `ev_blklen_i`, `ev_eraseseq_i` or `app_next_i` latches a flag at bit 31, 30, 29, 28 or 5 respectively, and the flag stays set until its clear condition occurs.
- R3: `rsp_word_o` changes only on the clock edge at which `cmd_ok_i` or `stat_req_i` is high. It then shows the live status as it stood before that edge, so events in that same cycle are not included. The new value is visible from the following cycle.
- R4: On an edge with `rsp_done_i` high, each of the bits 31, 30, 29, 28 and 5 that is 1 in `rsp_word_o` is cleared. A flag raised after the snapshot survives `rsp_done_i`, and without `rsp_done_i` no such flag clears.
- R5: An event pulse in the same cycle as a clear condition for its flag leaves the flag set.
- R6: Pulses on `ev_crc_i` and `ev_illegal_i` latch bits 23 and 22. These two flags clear on the next command edge (`cmd_ok_i` or `stat_req_i`), so each raised flag appears in exactly one response. `rsp_done_i` has no effect on them.
- R7: Bit 25 equals `locked_i`, bit 14 equals `ecc_off_i`, bit 8 equals `ready_i` and bits [12:9] equal `state_i`. All four are taken at the snapshot edge and are never latched.
- R8: Every bit not named in R2, R6 or R7 reads as zero.
- R9: An error raised after a command's snapshot does not alter the current response. The next command edge, such as a status request, brings it out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_ok_i | input | 1 | Valid command accepted (strobe) |
| stat_req_i | input | 1 | Status request command accepted (strobe) |
| rsp_done_i | input | 1 | Response carrying `rsp_word_o` has been sent (strobe) |
| ev_range_i | input | 1 | Argument out of range event |
| ev_addr_i | input | 1 | Misaligned or bad address event |
| ev_blklen_i | input | 1 | Illegal transfer length event |
| ev_eraseseq_i | input | 1 | Erase command order error event |
| ev_crc_i | input | 1 | Command checksum failure event |
| ev_illegal_i | input | 1 | Command not legal in current state event |
| app_next_i | input | 1 | Next command is an application command |
| locked_i | input | 1 | Card is locked (live) |
| ecc_off_i | input | 1 | Card ECC disabled (live) |
| ready_i | input | 1 | Buffer ready for data (live) |
| state_i | input | 4 | Current card state code (live) |
| rsp_word_o | output | 32 | Status word for the current response |

## Verification
A flag stuck at 1 shows on `rsp_word_o` at the first command edge after its clear, one cycle after that edge. A missed set shows at the first command edge after the event. A clear with the wrong policy differs from the model at the next snapshot taken after the wrong `rsp_done_i` or command edge. A snapshot taken on the wrong edge, or one that includes same-cycle events, changes the output in a cycle where the bench expects it to hold. For these reasons the bench compares the whole word on every cycle rather than only at the directed points.

// File: rtl/cs_pkg.sv
package cs_pkg;

  localparam int WORD_W   = 32;
  localparam int STATE_W  = 4;
  localparam int NFLAG    = 7;

  // Flag slot order inside the latched bank
  localparam int F_RANGE    = 0;
  localparam int F_ADDR     = 1;
  localparam int F_BLKLEN   = 2;
  localparam int F_ERASESEQ = 3;
  localparam int F_CRC      = 4;
  localparam int F_ILLEGAL  = 5;
  localparam int F_APPNEXT  = 6;

  // Positions of live card-state fields in the word
  localparam int POS_LOCKED   = 25;
  localparam int POS_ECC_OFF  = 14;
  localparam int POS_STATE_LO = 9;
  localparam int POS_READY    = 8;

  typedef enum logic {
    CLR_ON_READ     = 1'b0,
    CLR_ON_NEXT_CMD = 1'b1
  } clr_pol_e;

  // Bit position in the word for each latched flag slot
  function automatic int flag_pos(input int idx);
    case (idx)
      F_RANGE:    return 31;
      F_ADDR:     return 30;
      F_BLKLEN:   return 29;
      F_ERASESEQ: return 28;
      F_CRC:      return 23;
      F_ILLEGAL:  return 22;
      default:    return 5;
    endcase
  endfunction

  // Clear policy for each latched flag slot
  function automatic clr_pol_e flag_pol(input int idx);
    if (idx == F_CRC || idx == F_ILLEGAL) return CLR_ON_NEXT_CMD;
    return CLR_ON_READ;
  endfunction

  // Build the full status word from latched flags and live inputs
  function automatic logic [WORD_W-1:0] compose_word(
    input logic [NFLAG-1:0]   flags,
    input logic               locked,
    input logic               ecc_off,
    input logic               ready,
    input logic [STATE_W-1:0] st
  );
    logic [WORD_W-1:0] w;
    w = '0;
    for (int i = 0; i < NFLAG; i++) w[flag_pos(i)] = flags[i];
    w[POS_LOCKED]                 = locked;
    w[POS_ECC_OFF]                = ecc_off;
    w[POS_READY]                  = ready;
    w[POS_STATE_LO +: STATE_W]    = st;
    return w;
  endfunction

  // Pull each flag's bit back out of a word
  function automatic logic [NFLAG-1:0] extract_flags(input logic [WORD_W-1:0] w);
    logic [NFLAG-1:0] f;
    for (int i = 0; i < NFLAG; i++) f[i] = w[flag_pos(i)];
    return f;
  endfunction

  // Mask of every bit that carries a meaning
  function automatic logic [WORD_W-1:0] assigned_mask();
    return compose_word('1, 1'b1, 1'b1, 1'b1, '1);
  endfunction

endpackage

// File: rtl/cs_flag_cell.sv
module cs_flag_cell
  import cs_pkg::*;
#(
  parameter clr_pol_e POLICY = CLR_ON_READ
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic shown_i,
  input  logic rsp_done_i,
  input  logic cmd_i,
  output logic clr_o,
  output logic q_o
);

  always_comb begin
    if (POLICY == CLR_ON_READ) clr_o = rsp_done_i & shown_i;
    else                       clr_o = cmd_i;
  end

  // Set wins over clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_o) q_o <= 1'b0;
  end

endmodule

// File: rtl/cs_flag_bank.sv
module cs_flag_bank
  import cs_pkg::*;
#(
  parameter int N = NFLAG
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] shown_i,
  input  logic         rsp_done_i,
  input  logic         cmd_i,
  output logic [N-1:0] clr_o,
  output logic [N-1:0] flags_o
);

  for (genvar g = 0; g < N; g++) begin : g_cell
    cs_flag_cell #(.POLICY(flag_pol(g))) u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (set_i[g]),
      .shown_i    (shown_i[g]),
      .rsp_done_i (rsp_done_i),
      .cmd_i      (cmd_i),
      .clr_o      (clr_o[g]),
      .q_o        (flags_o[g])
    );
  end

endmodule

// File: rtl/cs_snapshot.sv
module cs_snapshot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture_i,
  input  logic [W-1:0] live_i,
  output logic [W-1:0] word_o
);

  always_ff @(posedge clk) begin
    if (!rst_n)         word_o <= '0;
    else if (capture_i) word_o <= live_i;
  end

endmodule

// File: rtl/cs_status_reg.sv
module cs_status_reg
  import cs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_ok_i,
  input  logic               stat_req_i,
  input  logic               rsp_done_i,
  input  logic               ev_range_i,
  input  logic               ev_addr_i,
  input  logic               ev_blklen_i,
  input  logic               ev_eraseseq_i,
  input  logic               ev_crc_i,
  input  logic               ev_illegal_i,
  input  logic               app_next_i,
  input  logic               locked_i,
  input  logic               ecc_off_i,
  input  logic               ready_i,
  input  logic [STATE_W-1:0] state_i,
  output logic [WORD_W-1:0]  rsp_word_o
);

  // Named internal events for the checker
  logic                cmd_any;
  logic [NFLAG-1:0]    set_vec;
  logic [NFLAG-1:0]    shown_vec;
  logic [NFLAG-1:0]    clr_vec;
  logic [NFLAG-1:0]    flags_q;
  logic [WORD_W-1:0]   live_word;

  assign cmd_any = cmd_ok_i | stat_req_i;

  always_comb begin
    set_vec             = '0;
    set_vec[F_RANGE]    = ev_range_i;
    set_vec[F_ADDR]     = ev_addr_i;
    set_vec[F_BLKLEN]   = ev_blklen_i;
    set_vec[F_ERASESEQ] = ev_eraseseq_i;
    set_vec[F_CRC]      = ev_crc_i;
    set_vec[F_ILLEGAL]  = ev_illegal_i;
    set_vec[F_APPNEXT]  = app_next_i;
  end

  assign shown_vec = extract_flags(rsp_word_o);

  cs_flag_bank #(.N(NFLAG)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (set_vec),
    .shown_i    (shown_vec),
    .rsp_done_i (rsp_done_i),
    .cmd_i      (cmd_any),
    .clr_o      (clr_vec),
    .flags_o    (flags_q)
  );

  assign live_word = compose_word(flags_q, locked_i, ecc_off_i, ready_i, state_i);

  cs_snapshot #(.W(WORD_W)) u_snap (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (cmd_any),
    .live_i    (live_word),
    .word_o    (rsp_word_o)
  );

endmodule

// File: rtl/cs_status_chk.sv
module cs_status_chk
  import cs_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_any,
  input logic               rsp_done_i,
  input logic               ev_range_i,
  input logic               ev_crc_i,
  input logic               locked_i,
  input logic [STATE_W-1:0] state_i,
  input logic [WORD_W-1:0]  live_word,
  input logic [WORD_W-1:0]  rsp_word_o
);

  // R3: no command edge, response word holds
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_any |=> $stable(rsp_word_o));

  // R8: unassigned bits stay zero
  p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_word_o & ~assigned_mask()) == '0);

  // R7: state code and lock bit copied at the snapshot edge
  p_state_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_any |=> (rsp_word_o[POS_STATE_LO +: STATE_W] == $past(state_i))
                && (rsp_word_o[POS_LOCKED] == $past(locked_i)));

  // R4: a shown read-clear flag goes away after the response is sent
  p_read_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done_i && rsp_word_o[31] && !ev_range_i |=> !live_word[31]);

  // R5: an event always leaves its flag set
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_range_i |=> live_word[31]);

  // R6: next command clears the checksum flag
  p_cmd_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_any && !ev_crc_i |=> !live_word[23]);

  // R6: without a command edge or event the checksum flag holds
  p_cmd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_any && !ev_crc_i |=> $stable(live_word[23]));

endmodule

bind cs_status_reg cs_status_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_any    (cmd_any),
  .rsp_done_i (rsp_done_i),
  .ev_range_i (ev_range_i),
  .ev_crc_i   (ev_crc_i),
  .locked_i   (locked_i),
  .state_i    (state_i),
  .live_word  (live_word),
  .rsp_word_o (rsp_word_o)
);

// File: tb/tb_cs_status_reg.sv
module tb_cs_status_reg;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_ok = 0, stat_req = 0, rsp_done = 0;
  logic        ev_range = 0, ev_addr = 0, ev_blklen = 0, ev_eraseseq = 0;
  logic        ev_crc = 0, ev_illegal = 0, app_next = 0;
  logic        locked = 0, ecc_off = 0, ready = 0;
  logic [3:0]  state = 0;
  logic [31:0] rsp_word;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  cs_status_reg dut (
    .clk(clk), .rst_n(rst_n), .cmd_ok_i(cmd_ok), .stat_req_i(stat_req),
    .rsp_done_i(rsp_done), .ev_range_i(ev_range), .ev_addr_i(ev_addr),
    .ev_blklen_i(ev_blklen), .ev_eraseseq_i(ev_eraseseq), .ev_crc_i(ev_crc),
    .ev_illegal_i(ev_illegal), .app_next_i(app_next), .locked_i(locked),
    .ecc_off_i(ecc_off), .ready_i(ready), .state_i(state), .rsp_word_o(rsp_word)
  );

  // ---------------- behavioural reference model ----------------
  localparam logic [31:0] READ_CLR = 32'hF000_0020;
  localparam logic [31:0] CMD_CLR  = 32'h00C0_0000;
  logic [31:0] m_sticky = 0;
  logic [31:0] m_snap   = 0;

  always @(posedge clk) begin
    logic [31:0] live, setm, clrm;
    if (!rst_n) begin
      m_sticky = 0;
      m_snap   = 0;
    end else begin
      live = m_sticky | ({31'd0, locked} << 25) | ({31'd0, ecc_off} << 14)
           | ({31'd0, ready} << 8) | ({28'd0, state} << 9);
      setm = ({31'd0, ev_range} << 31) | ({31'd0, ev_addr} << 30)
           | ({31'd0, ev_blklen} << 29) | ({31'd0, ev_eraseseq} << 28)
           | ({31'd0, ev_crc} << 23) | ({31'd0, ev_illegal} << 22)
           | ({31'd0, app_next} << 5);
      clrm = 0;
      if (rsp_done) clrm = clrm | (m_snap & READ_CLR);
      if (cmd_ok || stat_req) clrm = clrm | CMD_CLR;
      if (cmd_ok || stat_req) m_snap = live;
      m_sticky = (m_sticky & ~clrm) | setm;
    end
  end

  // Whole-word compare every cycle, split by requirement
  always @(negedge clk) begin
    if (rst_n) begin
      n_tests++;
      if ((rsp_word & READ_CLR) !== (m_snap & READ_CLR)) begin
        n_fail++;
        $display("FAIL R4 read-clear bits act=%h exp=%h", rsp_word & READ_CLR, m_snap & READ_CLR);
      end
      n_tests++;
      if ((rsp_word & CMD_CLR) !== (m_snap & CMD_CLR)) begin
        n_fail++;
        $display("FAIL R6 next-cmd bits act=%h exp=%h", rsp_word & CMD_CLR, m_snap & CMD_CLR);
      end
      n_tests++;
      if ((rsp_word & ~(READ_CLR | CMD_CLR)) !== (m_snap & ~(READ_CLR | CMD_CLR))) begin
        n_fail++;
        $display("FAIL R7/R8 live and unused bits act=%h exp=%h",
                 rsp_word & ~(READ_CLR | CMD_CLR), m_snap & ~(READ_CLR | CMD_CLR));
      end
    end
  end

  // ---------------- directed checks ----------------
  task automatic check(input logic [31:0] exp, input string tag);
    n_tests++;
    if (rsp_word !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, rsp_word, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_cmd();
    cmd_ok = 1; tick(); cmd_ok = 0;
  endtask

  task automatic do_stat();
    stat_req = 1; tick(); stat_req = 0;
  endtask

  task automatic do_done();
    rsp_done = 1; tick(); rsp_done = 0;
  endtask

  initial begin
    #(8 * 5000);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    check(32'h0, "R1 reset word");

    // R2: range flag latched, seen at next command
    ev_range = 1; tick(); ev_range = 0;
    tick();
    check(32'h0, "R3 no command no change");
    do_cmd();
    check(32'h8000_0000, "R2 range flag");
    // R4: sent response clears it
    do_done();
    do_cmd();
    check(32'h0, "R4 cleared after send");

    // R2: app flag
    app_next = 1; tick(); app_next = 0;
    do_cmd();
    check(32'h0000_0020, "R2 app flag");
    do_done();

    // R5: set in same cycle as read clear wins
    ev_addr = 1; tick(); ev_addr = 0;
    do_cmd();
    check(32'h4000_0000, "R2 addr flag");
    rsp_done = 1; ev_addr = 1; tick(); rsp_done = 0; ev_addr = 0;
    do_cmd();
    check(32'h4000_0000, "R5 set beats clear");
    do_done();
    do_cmd();
    check(32'h0, "R4 addr cleared");

    // R3/R9: event in same cycle as command not in this response
    cmd_ok = 1; ev_blklen = 1; tick(); cmd_ok = 0; ev_blklen = 0;
    check(32'h0, "R3 same-cycle event excluded");
    ev_eraseseq = 1; tick(); ev_eraseseq = 0;
    check(32'h0, "R9 execution error hidden");
    do_stat();
    check(32'h3000_0000, "R9 status request reveals");

    // R4: flag raised after snapshot survives send
    do_done();
    ev_range = 1; tick(); ev_range = 0;
    do_done();
    do_stat();
    check(32'h8000_0000, "R4 unseen flag kept");
    do_done();

    // R6: checksum flag shown once, cleared by next command
    ev_crc = 1; tick(); ev_crc = 0;
    do_cmd();
    check(32'h0080_0000, "R6 crc shown");
    do_cmd();
    check(32'h0, "R6 crc cleared by next command");

    // R6: send does not clear; set with command wins
    cmd_ok = 1; ev_illegal = 1; tick(); cmd_ok = 0; ev_illegal = 0;
    do_done();
    do_done();
    do_stat();
    check(32'h0040_0000, "R6 illegal kept across sends");
    do_cmd();
    check(32'h0, "R6 illegal cleared");

    // R7: live fields copied at snapshot, not latched
    locked = 1; ready = 1; state = 4'd5; ecc_off = 1;
    do_cmd();
    check(32'h0200_4B00, "R7 live fields");
    locked = 0; ready = 0; state = 4'd9; ecc_off = 0;
    tick();
    check(32'h0200_4B00, "R3 live change held");
    do_cmd();
    check(32'h0000_1200, "R7 follows without latch");

    // Mixed pattern, all sticky together (model compares each cycle)
    ev_range = 1; ev_addr = 1; ev_blklen = 1; ev_eraseseq = 1;
    ev_crc = 1; ev_illegal = 1; app_next = 1; state = 4'hF;
    tick();
    ev_range = 0; ev_addr = 0; ev_blklen = 0; ev_eraseseq = 0;
    ev_crc = 0; ev_illegal = 0; app_next = 0;
    do_cmd();
    check(32'hF0C0_1E20, "R8 full word only assigned bits");
    do_done();
    do_cmd();
    check(32'h0000_1E00, "R4 R6 all cleared");

    tick();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule